// File: doc/BRIEF.md
# NAND Bus Command Front End

This block is the device-side front end of a byte-wide multiplexed NAND bus. The host drives an 8-bit bus and a write strobe. With chip select low, each rising strobe edge delivers either a command byte (command-latch high), an address byte (address-latch high) or a data byte (both low). The block walks through the command and address phases of page read, page program, block erase, status read, identification read and reset. It drives a ready/busy line and answers read strobes with a status byte, an identification byte or page data.

Array work is not modelled as cell storage. A page load, a program or an erase is a busy window whose length is a parameter in clock cycles. Both strobes are sampled against the system clock, so an edge takes effect on the first clock after the block sees it. The latched column and row addresses are presented on output ports for the array side.

Top module: `nand_cmd_front`

## Requirements
- R1: After system reset, rdy is 1, io_oe is 0, col_addr and row_addr are 0, the output mode is first-half page read, and a status read with write protect high returns C0h.
- R2: A read command (00h, 01h or 50h) followed by three address bytes stores byte 1 as the column, byte 2 in row_addr[7:0] and byte 3 in row_addr[15:8]. rdy goes to 0 on the clock after the third strobe and stays at 0 for exactly T_READ clocks.
- R3: The column register is 10 bits, {area[1:0], offset[7:0]}. 00h selects area 00 with the full byte as offset. 01h selects area 01. 50h selects area 10 with offset {4'b0, byte[3:0]}, so address bits 7:4 are ignored.
- R4: The status byte is {wp_n, ready, 5'b00000, fail}. Bit 6 is 0 while busy, bits 5..1 are always 0, and bit 0 is 1 only after a rejected confirm.
- R5: 80h, three address bytes, at least one data byte and then 10h starts a program: rdy is low for exactly T_PROG clocks. A 10h with no data byte entered after the addresses starts nothing.
- R6: 60h followed by two address bytes loads row_addr[7:0] and then row_addr[15:8]. A following D0h holds rdy low for exactly T_ERASE clocks. A D0h without that setup starts nothing.
- R7: While busy, only 70h and FFh are acted on. Every other command byte, and every address or data byte, leaves the mode and the addresses unchanged.
- R8: FFh aborts any operation and holds rdy low for exactly T_RST clocks. It clears col_addr, row_addr and the fail bit and returns to first-half read mode. An FFh that arrives while a reset window is running is ignored and does not extend it.
- R9: 90h followed by one address byte selects identification output. Successive read cycles return ECh, then 73h, then 00h from then on.
- R10: Status mode and identification mode persist across any number of read cycles until another command byte arrives. In status mode, address bytes with no command start nothing. In read mode, three address bytes with no command start a new page read.
- R11: With wp_n low, 10h and D0h confirms start nothing, set the fail bit, and status bit 7 reads 0.
- R12: Strobes taken with ce_n high have no effect, and io_oe is 1 only while both ce_n and re_n are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks a command byte |
| ale | input | 1 | Marks an address byte |
| we_n | input | 1 | Write strobe; the bus is taken on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Status, identification or page data byte |
| io_oe | output | 1 | Output enable for io_out |
| rdy | output | 1 | Ready (1) / busy (0) |
| col_addr | output | 10 | Latched column: area and offset |
| row_addr | output | 16 | Latched row address |

## Verification
A strobe edge is seen one clock after it happens. Its effect on mode, addresses and rdy is registered on the next clock edge, so the bench drives inputs on falling clock edges and samples one falling edge after the strobe rises. A busy window of N clocks is checked twice: rdy must still be 0 after N-1 further clocks and must be 1 after N. A count that is one too long or one too short therefore fails. For read data, io_out is sampled while re_n is low. The identification index only advances on the clock after re_n rises, and a repeated reset is checked against the end time of the first reset window.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  localparam int COL_W = 10;
  localparam int ROW_W = 16;

  localparam logic [7:0] CMD_READ_LO     = 8'h00;
  localparam logic [7:0] CMD_READ_HI     = 8'h01;
  localparam logic [7:0] CMD_READ_SP     = 8'h50;
  localparam logic [7:0] CMD_ID          = 8'h90;
  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
  localparam logic [7:0] CMD_PROG_GO     = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;

  localparam logic [7:0] ID_MAKER  = 8'hEC;
  localparam logic [7:0] ID_DEVICE = 8'h73;

  typedef enum logic [1:0] {OM_READ1, OM_READ2, OM_STATUS, OM_ID} out_mode_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_ECONF} seq_e;
  typedef enum logic [1:0] {OK_READ, OK_PROG, OK_ERASE, OK_ID} op_kind_e;
  typedef enum logic [1:0] {TM_READ, TM_PROG, TM_ERASE, TM_RST} tmr_sel_e;

  // index of the final address byte for each operation
  function automatic logic [1:0] last_idx(op_kind_e k);
    case (k)
      OK_ERASE: return 2'd1;
      OK_ID:    return 2'd0;
      default:  return 2'd2;
    endcase
  endfunction

  // destination of an address byte: 0 column, 1 row low, 2 row high
  function automatic logic [1:0] slot_of(op_kind_e k, logic [1:0] idx);
    return (k == OK_ERASE) ? idx + 2'd1 : idx;
  endfunction

  function automatic logic [1:0] area_of(logic [7:0] code);
    case (code)
      CMD_READ_HI: return 2'b01;
      CMD_READ_SP: return 2'b10;
      default:     return 2'b00;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] col_word(logic [1:0] area, logic [7:0] b);
    return (area == 2'b10) ? {area, 4'h0, b[3:0]} : {area, b};
  endfunction

  function automatic logic [7:0] status_byte(logic wp_n, logic busy, logic fail);
    return {wp_n, ~busy, 5'b00000, fail};
  endfunction

  function automatic logic [7:0] id_byte(logic [1:0] idx);
    case (idx)
      2'd0:    return ID_MAKER;
      2'd1:    return ID_DEVICE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic legal_when_busy(logic [7:0] code, logic in_reset);
    return (code == CMD_STATUS) || ((code == CMD_RESET) && !in_reset);
  endfunction

endpackage

// File: rtl/nand_strobe_sampler.sv
module nand_strobe_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_evt,
  output logic addr_evt,
  output logic data_evt,
  output logic re_rise
);
  logic we_q, re_q;
  logic we_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_rise  = we_n & ~we_q & ~ce_n;
  assign cmd_evt  = we_rise &  cle & ~ale;
  assign addr_evt = we_rise & ~cle &  ale;
  assign data_evt = we_rise & ~cle & ~ale;
  assign re_rise  = re_n & ~re_q & ~ce_n;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer
  import nand_cmd_pkg::*;
#(
  parameter int T_READ  = 500,
  parameter int T_PROG  = 15000,
  parameter int T_ERASE = 100000,
  parameter int T_RST   = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  tmr_sel_e sel,
  output logic     busy,
  output logic     rst_busy
);
  localparam int MAX_AB = (T_READ > T_PROG) ? T_READ : T_PROG;
  localparam int MAX_CD = (T_ERASE > T_RST) ? T_ERASE : T_RST;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;

  function automatic logic [CNT_W-1:0] dur(tmr_sel_e s);
    case (s)
      TM_PROG:  return CNT_W'(T_PROG);
      TM_ERASE: return CNT_W'(T_ERASE);
      TM_RST:   return CNT_W'(T_RST);
      default:  return CNT_W'(T_READ);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (start) begin
      cnt_q <= dur(sel);
      rst_q <= (sel == TM_RST);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign busy     = (cnt_q != '0);
  assign rst_busy = busy & rst_q;
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_evt,
  input  logic             addr_evt,
  input  logic             data_evt,
  input  logic             re_rise,
  input  logic             busy,
  input  logic             rst_busy,
  input  logic             wp_n,
  input  logic [7:0]       bus_byte,
  output logic             op_start,
  output tmr_sel_e         op_sel,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr,
  output out_mode_e        out_mode,
  output logic             fail_flag,
  output logic [1:0]       id_idx
);
  seq_e       seq_q;
  op_kind_e   kind_q, cur_kind;
  logic [1:0] idx_q, cur_idx, area_q;
  logic       have_data_q;
  logic       cmd_ok, prog_go, erase_go, rst_go, read_go;
  logic       addr_ok, addr_new, addr_take, addr_last;
  logic       in_read_mode;

  assign in_read_mode = (out_mode == OM_READ1) || (out_mode == OM_READ2);
  assign cmd_ok   = cmd_evt && (!busy || legal_when_busy(bus_byte, rst_busy));
  assign prog_go  = cmd_ok && (bus_byte == CMD_PROG_GO) && (seq_q == SQ_DATA) && have_data_q;
  assign erase_go = cmd_ok && (bus_byte == CMD_ERASE_GO) && (seq_q == SQ_ECONF);
  assign rst_go   = cmd_ok && (bus_byte == CMD_RESET);

  assign addr_ok   = addr_evt && !busy;
  assign addr_new  = addr_ok && (seq_q == SQ_IDLE) && in_read_mode;
  assign cur_kind  = addr_new ? OK_READ : kind_q;
  assign cur_idx   = addr_new ? 2'd0 : idx_q;
  assign addr_take = addr_ok && ((seq_q == SQ_ADDR) || addr_new);
  assign addr_last = addr_take && (cur_idx == last_idx(cur_kind));
  assign read_go   = addr_last && (cur_kind == OK_READ);

  assign op_start = rst_go | read_go | ((prog_go | erase_go) & wp_n);

  always_comb begin
    if (rst_go)        op_sel = TM_RST;
    else if (prog_go)  op_sel = TM_PROG;
    else if (erase_go) op_sel = TM_ERASE;
    else               op_sel = TM_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q       <= SQ_IDLE;
      kind_q      <= OK_READ;
      idx_q       <= 2'd0;
      area_q      <= 2'b00;
      have_data_q <= 1'b0;
      out_mode    <= OM_READ1;
      fail_flag   <= 1'b0;
      id_idx      <= 2'd0;
      col_addr    <= '0;
      row_addr    <= '0;
    end else if (cmd_ok) begin
      case (bus_byte)
        CMD_READ_LO, CMD_READ_HI, CMD_READ_SP: begin
          seq_q    <= SQ_ADDR;
          kind_q   <= OK_READ;
          idx_q    <= 2'd0;
          area_q   <= area_of(bus_byte);
          out_mode <= (bus_byte == CMD_READ_SP) ? OM_READ2 : OM_READ1;
        end
        CMD_ID: begin
          seq_q    <= SQ_ADDR;
          kind_q   <= OK_ID;
          idx_q    <= 2'd0;
          out_mode <= OM_ID;
          id_idx   <= 2'd0;
        end
        CMD_STATUS: begin
          seq_q    <= SQ_IDLE;
          out_mode <= OM_STATUS;
        end
        CMD_PROG_SETUP, CMD_ERASE_SETUP: begin
          seq_q       <= SQ_ADDR;
          kind_q      <= (bus_byte == CMD_PROG_SETUP) ? OK_PROG : OK_ERASE;
          idx_q       <= 2'd0;
          have_data_q <= 1'b0;
          if (!in_read_mode) begin
            out_mode <= OM_READ1;
            area_q   <= 2'b00;
          end
        end
        CMD_PROG_GO, CMD_ERASE_GO: begin
          seq_q <= SQ_IDLE;
          if (prog_go || erase_go) fail_flag <= ~wp_n;
        end
        CMD_RESET: begin
          seq_q       <= SQ_IDLE;
          kind_q      <= OK_READ;
          idx_q       <= 2'd0;
          area_q      <= 2'b00;
          have_data_q <= 1'b0;
          out_mode    <= OM_READ1;
          fail_flag   <= 1'b0;
          id_idx      <= 2'd0;
          col_addr    <= '0;
          row_addr    <= '0;
        end
        default: seq_q <= SQ_IDLE;
      endcase
    end else if (addr_take) begin
      case (slot_of(cur_kind, cur_idx))
        2'd0:    if (cur_kind != OK_ID) col_addr <= col_word(area_q, bus_byte);
        2'd1:    row_addr[7:0]  <= bus_byte;
        default: row_addr[15:8] <= bus_byte;
      endcase
      kind_q <= cur_kind;
      idx_q  <= cur_idx + 2'd1;
      if (!addr_last)                seq_q <= SQ_ADDR;
      else if (cur_kind == OK_PROG)  seq_q <= SQ_DATA;
      else if (cur_kind == OK_ERASE) seq_q <= SQ_ECONF;
      else                           seq_q <= SQ_IDLE;
    end else if (data_evt && !busy && (seq_q == SQ_DATA)) begin
      have_data_q <= 1'b1;
    end else if (re_rise && (out_mode == OM_ID) && (id_idx != 2'd2)) begin
      id_idx <= id_idx + 2'd1;
    end
  end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_cmd_pkg::*;
#(
  parameter int T_READ  = 500,
  parameter int T_PROG  = 15000,
  parameter int T_ERASE = 100000,
  parameter int T_RST   = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic             wp_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             rdy,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr
);
  logic       cmd_evt, addr_evt, data_evt, re_rise;
  logic       busy, rst_busy, op_start, fail_flag;
  tmr_sel_e   op_sel;
  out_mode_e  out_mode;
  logic [1:0] id_idx;

  nand_strobe_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .cmd_evt(cmd_evt), .addr_evt(addr_evt),
    .data_evt(data_evt), .re_rise(re_rise)
  );

  nand_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .addr_evt(addr_evt),
    .data_evt(data_evt), .re_rise(re_rise), .busy(busy), .rst_busy(rst_busy),
    .wp_n(wp_n), .bus_byte(io_in), .op_start(op_start), .op_sel(op_sel),
    .col_addr(col_addr), .row_addr(row_addr), .out_mode(out_mode),
    .fail_flag(fail_flag), .id_idx(id_idx)
  );

  nand_busy_timer #(
    .T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(op_start), .sel(op_sel),
    .busy(busy), .rst_busy(rst_busy)
  );

  always_comb begin
    case (out_mode)
      OM_STATUS: io_out = status_byte(wp_n, busy, fail_flag);
      OM_ID:     io_out = id_byte(id_idx);
      default:   io_out = 8'hFF;
    endcase
  end

  assign io_oe = ~ce_n & ~re_n;
  assign rdy   = ~busy;
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk
  import nand_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_evt,
  input logic [7:0]       io_in,
  input logic             wp_n,
  input logic             busy,
  input logic             op_start,
  input out_mode_e        out_mode,
  input logic [COL_W-1:0] col_addr,
  input logic [ROW_W-1:0] row_addr,
  input logic [7:0]       io_out,
  input logic             io_oe
);
  AST_START_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy); // R2

  AST_WP_BLOCKS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && !wp_n && (io_in == CMD_PROG_GO || io_in == CMD_ERASE_GO)) |-> !op_start); // R11

  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_evt && io_in != CMD_STATUS && io_in != CMD_RESET)
      |=> ($stable(out_mode) && $stable(row_addr) && $stable(col_addr))); // R7

  AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && out_mode == OM_STATUS) |-> (io_out[5:1] == 5'd0 && io_out[6] == !busy)); // R4

  AST_ID_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe && out_mode == OM_ID) |-> (io_out == ID_MAKER || io_out == ID_DEVICE || io_out == 8'h00)); // R9
endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .io_in(io_in), .wp_n(wp_n),
  .busy(busy), .op_start(op_start), .out_mode(out_mode), .col_addr(col_addr),
  .row_addr(row_addr), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/nand_cmd_front_bench.sv
module nand_cmd_front_bench;
  localparam int TR = 5, TP = 9, TE = 12, TRS = 8;

  logic clk = 0, rst_n = 0;
  logic ce_n = 0, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1;
  logic [7:0] io_in = 0;
  logic [7:0] io_out;
  logic io_oe, rdy;
  logic [9:0] col_addr;
  logic [15:0] row_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nand_cmd_front #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .T_RST(TRS)) u_nand_cmd_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rdy(rdy), .col_addr(col_addr), .row_addr(row_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic c, logic a, logic [7:0] b);
    cle = c; ale = a; io_in = b; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic cmd(logic [7:0] b); strobe(1, 0, b); endtask
  task automatic adr(logic [7:0] b); strobe(0, 1, b); endtask

  task automatic rd(output logic [7:0] v, output logic oe);
    re_n = 0;
    @(negedge clk); v = io_out; oe = io_oe; re_n = 1;
    @(negedge clk);
  endtask

  task automatic busy_for(string req, int n);
    chk(req, rdy, 0);
    wait_n(n - 1); chk(req, rdy, 0);
    wait_n(1);     chk(req, rdy, 1);
  endtask

  task automatic status_is(string req, logic [7:0] exp);
    logic [7:0] v; logic oe;
    cmd(8'h70); rd(v, oe); chk(req, v, exp); chk(req, oe, 1);
  endtask

  task automatic t_reset_state;
    chk("R1 rdy", rdy, 1); chk("R1 oe", io_oe, 0);
    chk("R1 col", col_addr, 0); chk("R1 row", row_addr, 0);
    status_is("R1 status", 8'hC0);
  endtask

  task automatic t_read1;
    logic [7:0] v; logic oe;
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h56);
    busy_for("R2 tR", TR);
    chk("R2 col", col_addr, 10'h012); chk("R2 row", row_addr, 16'h5634);
    rd(v, oe); chk("R2 data", v, 8'hFF);
  endtask

  task automatic t_areas;
    cmd(8'h50); adr(8'hA7); adr(8'h01); adr(8'h02);
    busy_for("R3 spare busy", TR); chk("R3 spare col", col_addr, 10'h207);
    cmd(8'h01); adr(8'h40); adr(8'h01); adr(8'h02);
    busy_for("R3 half busy", TR); chk("R3 half col", col_addr, 10'h140);
  endtask

  task automatic t_sticky;
    logic [7:0] v; logic oe;
    cmd(8'h70); rd(v, oe); chk("R10 st1", v, 8'hC0); rd(v, oe); chk("R10 st2", v, 8'hC0);
    adr(8'h11); adr(8'h22); adr(8'h33); wait_n(1);
    chk("R10 no read rdy", rdy, 1); chk("R10 no read row", row_addr, 16'h0201);
    rd(v, oe); chk("R10 still status", v, 8'hC0);
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); busy_for("R10 read", TR);
    adr(8'h44); adr(8'h55); adr(8'h66);
    busy_for("R10 addr only read", TR); chk("R10 new row", row_addr, 16'h6655);
  endtask

  task automatic t_id;
    logic [7:0] v; logic oe;
    cmd(8'h90); adr(8'h00); chk("R9 no busy", rdy, 1);
    rd(v, oe); chk("R9 maker", v, 8'hEC);
    rd(v, oe); chk("R9 device", v, 8'h73);
    rd(v, oe); chk("R9 after", v, 8'h00);
    rd(v, oe); chk("R9 sticky", v, 8'h00);
  endtask

  task automatic t_prog;
    logic [7:0] v; logic oe;
    cmd(8'h80); adr(8'h00); adr(8'h10); adr(8'h20); cmd(8'h10); wait_n(1);
    chk("R5 no data no start", rdy, 1);
    cmd(8'h80); adr(8'h00); adr(8'h10); adr(8'h20); strobe(0, 0, 8'hAA); cmd(8'h10);
    busy_for("R5 tPROG", TP);
    cmd(8'h80); adr(8'h00); adr(8'h10); adr(8'h20); strobe(0, 0, 8'h55); cmd(8'h10);
    cmd(8'h70); rd(v, oe); chk("R4 busy status", v, 8'h80);
    wait_n(TP); rd(v, oe); chk("R4 ready status", v, 8'hC0);
  endtask

  task automatic t_erase;
    cmd(8'hD0); wait_n(1); chk("R6 lone confirm", rdy, 1);
    cmd(8'h60); adr(8'h05); adr(8'h07);
    chk("R6 row", row_addr, 16'h0705); chk("R6 col kept", col_addr, 10'h000);
    cmd(8'hD0); busy_for("R6 tBERS", TE);
  endtask

  task automatic t_busy_filter;
    logic [7:0] v; logic oe;
    cmd(8'h60); adr(8'h09); adr(8'h0A); cmd(8'hD0);
    cmd(8'h70); cmd(8'h90); adr(8'h77); cmd(8'h00);
    chk("R7 row", row_addr, 16'h0A09);
    rd(v, oe); chk("R7 mode kept", v, 8'h80);
    wait_n(TE); rd(v, oe); chk("R7 status after", v, 8'hC0);
  endtask

  task automatic t_wp;
    wp_n = 0;
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0); wait_n(1);
    chk("R11 erase rejected", rdy, 1);
    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h02); strobe(0, 0, 8'h00); cmd(8'h10); wait_n(1);
    chk("R11 prog rejected", rdy, 1);
    status_is("R11 status", 8'h41);
    wp_n = 1;
  endtask

  task automatic t_reset_cmd;
    cmd(8'hFF); chk("R8 col", col_addr, 0); chk("R8 row", row_addr, 0);
    busy_for("R8 tRST", TRS);
    status_is("R8 status", 8'hC0);
    cmd(8'h80); adr(8'h03); adr(8'h04); adr(8'h05); strobe(0, 0, 8'h12); cmd(8'h10);
    wait_n(2); cmd(8'hFF); chk("R8 abort busy", rdy, 0);
    wait_n(1); cmd(8'hFF); chk("R8 repeat busy", rdy, 0);
    wait_n(TRS - 4); chk("R8 repeat ignored", rdy, 0);
    wait_n(1); chk("R8 repeat ignored end", rdy, 1);
  endtask

  task automatic t_ce;
    logic [7:0] v; logic oe;
    ce_n = 1; adr(8'h77); adr(8'h88); adr(8'h99); cmd(8'h70);
    chk("R12 oe off", io_oe, 0);
    ce_n = 0; wait_n(1);
    chk("R12 no read", rdy, 1); chk("R12 row", row_addr, 0);
    rd(v, oe); chk("R12 mode", v, 8'hFF); chk("R12 oe on", oe, 1);
  endtask

  initial begin
    wait_n(3); rst_n = 1; wait_n(2);
    t_reset_state; t_read1; t_areas; t_sticky; t_id; t_prog;
    t_erase; t_busy_filter; t_wp; t_reset_cmd; t_ce;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule